// File: doc/BRIEF.md
# Digitally Controlled Sampling Clock Divider

This block turns a fast master clock (above 40 MHz) into a one-cycle sample-enable stream whose average rate is a programmable fraction of the master rate. The usual target is 9.728 MHz, which is 512 times the 19 kHz stereo pilot. The block does not divide by an integer. A 32-bit phase accumulator adds an increment on every master cycle, and each carry out of the accumulator produces one enable pulse. The pulses are therefore not evenly spaced: consecutive gaps differ by at most one master cycle, and the long-run average is exact.

Software programs a nominal increment that suits the master frequency. A pilot-locking loop outside the block then steers the rate with up and down strobes. Each strobe moves a signed trim by one step, and the trim saturates at a symmetric limit. The trim stays in force when the strobes go quiet, as they do during mono reception. A preset bit forces the increment to the nominal value, makes the block ignore the strobes and clears the trim. Preset is used for sources that carry no pilot. The increment in force can be read back at all times.

Top module: `dcs_sample_clock`

## Requirements
- R1: After a synchronous active-low reset, the accumulator and the trim are zero, `smp_en` is low and `cur_inc` equals `nominal_inc`.
- R2: On every master cycle the accumulator adds `cur_inc` modulo 2^32. `smp_en` is high for exactly the one cycle after an add that carries out. With a steady increment `inc`, L cycles after reset release yield floor(L*inc/2^32) pulses.
- R3: With a steady increment, every gap between consecutive pulses is floor(2^32/inc) or the next integer up, and the gap is exactly 2^32/inc when that division is exact.
- R4: Outside preset, `cur_inc` equals `nominal_inc` plus the signed trim, with one trim step worth one increment LSB. The trim holds its value while no strobe is present.
- R5: Outside preset, a cycle with `up_pulse` high and `dn_pulse` low raises the trim by one step, and the opposite case lowers it by one step. The change is visible on `cur_inc` in the following cycle.
- R6: The trim saturates at +1024 and -1024 steps. Further strobes in the same direction leave it unchanged.
- R7: A cycle with both strobes high leaves the trim unchanged.
- R8: While `preset` is high, `cur_inc` equals `nominal_inc` and the strobes have no effect. The trim is cleared on the first clock edge with `preset` high, so `cur_inc` equals `nominal_inc` after `preset` is released.
- R9: When the sum of the nominal increment and the trim falls outside the 32-bit range, `cur_inc` is clamped to 0 or to 2^32-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nominal_inc | input | 32 | Programmed nominal phase increment |
| preset | input | 1 | Forces the nominal increment and clears the trim |
| up_pulse | input | 1 | One-cycle request to raise the rate by one step |
| dn_pulse | input | 1 | One-cycle request to lower the rate by one step |
| smp_en | output | 1 | One-cycle sample-enable pulse |
| cur_inc | output | 32 | Increment currently in force |

## Verification
The assertions check the trim register on every cycle. They confirm that it stays inside the saturation bounds, moves by exactly one step on a lone up strobe, holds still when both strobes arrive together, and is zero after any cycle in preset. They also check that every enable pulse matches a wrap of the phase accumulator. Other properties cover whole runs of cycles rather than single cycles, so only the bench scenarios can show them. These are the pulse count and gap spacing for integer and fractional ratios, the clamping of the summed increment at both ends of its range, and the readback value after preset is released.

// File: rtl/dcs_pkg.sv
// Shared types for the sampling clock divider.
// Assumes: strobes are single-cycle and synchronous to the master clock.
package dcs_pkg;

    // Action applied to the trim register in one cycle
    typedef enum logic [1:0] {
        TRIM_HOLD  = 2'd0,
        TRIM_UP    = 2'd1,
        TRIM_DOWN  = 2'd2,
        TRIM_CLEAR = 2'd3
    } trim_op_e;

    // Map preset and strobe inputs to a trim action; preset wins, opposite strobes cancel
    function automatic trim_op_e decode_trim_op(input logic preset_i,
                                                input logic up_i,
                                                input logic dn_i);
        trim_op_e op;
        if (preset_i)
            op = TRIM_CLEAR;
        else if (up_i && !dn_i)
            op = TRIM_UP;
        else if (dn_i && !up_i)
            op = TRIM_DOWN;
        else
            op = TRIM_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/dcs_trim_ctrl.sv
// Signed saturating trim register steered by up/down strobes.
// Does: one step per lone strobe, cancel on both, clear while preset.
// Assumes: TRIM_W is wide enough to hold +/-TRIM_LIMIT.
module dcs_trim_ctrl
    import dcs_pkg::*;
#(
    parameter int TRIM_LIMIT = 1024,
    parameter int TRIM_W     = $clog2(TRIM_LIMIT + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     preset,
    input  logic                     up_pulse,
    input  logic                     dn_pulse,
    output logic signed [TRIM_W-1:0] trim_q
);

    localparam logic signed [TRIM_W-1:0] TRIM_MAX  = TRIM_W'(TRIM_LIMIT);
    localparam logic signed [TRIM_W-1:0] TRIM_MIN  = -TRIM_MAX;
    localparam logic signed [TRIM_W-1:0] TRIM_ONE  = TRIM_W'(1);
    localparam logic signed [TRIM_W-1:0] TRIM_ZERO = '0;

    trim_op_e                  op;
    logic signed [TRIM_W-1:0]  trim_d;

    // Decode this cycle's action from preset and strobes
    always_comb op = decode_trim_op(preset, up_pulse, dn_pulse);

    // Next trim value with saturation at both limits
    always_comb begin
        trim_d = trim_q;
        unique case (op)
            TRIM_UP:    if (trim_q < TRIM_MAX) trim_d = trim_q + TRIM_ONE;
            TRIM_DOWN:  if (trim_q > TRIM_MIN) trim_d = trim_q - TRIM_ONE;
            TRIM_CLEAR: trim_d = TRIM_ZERO;
            default:    trim_d = trim_q;
        endcase
    end

    // Trim register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) trim_q <= TRIM_ZERO;
        else        trim_q <= trim_d;
    end

    // R6: trim never leaves the saturation window
    p_trim_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_q <= TRIM_MAX) && (trim_q >= TRIM_MIN));

    // R5: lone up strobe below the limit raises the trim by exactly one
    p_up_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && !dn_pulse && !preset && trim_q != TRIM_MAX)
        |=> trim_q == $past(trim_q) + TRIM_ONE);

    // R7: simultaneous strobes leave the trim alone
    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && dn_pulse && !preset) |=> $stable(trim_q));

    // R8: any cycle in preset leaves the trim at zero
    p_preset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> trim_q == TRIM_ZERO);

endmodule

// File: rtl/dcs_inc_sum.sv
// Combines nominal increment and trim into the increment in force.
// Does: sign-extends and scales the trim, adds, clamps to the unsigned range;
//       preset bypasses the trim entirely.
// Assumes: ACC_W + 2 exceeds the scaled trim width.
module dcs_inc_sum #(
    parameter int ACC_W      = 32,
    parameter int TRIM_W     = 12,
    parameter int STEP_SHIFT = 0
) (
    input  logic                     preset,
    input  logic [ACC_W-1:0]         nominal_inc,
    input  logic signed [TRIM_W-1:0] trim,
    output logic [ACC_W-1:0]         inc
);

    localparam int SUM_W = ACC_W + 2;

    logic signed [SUM_W-1:0] nom_ext;
    logic signed [SUM_W-1:0] trim_ext;
    logic signed [SUM_W-1:0] sum;

    // Widen both operands so the sum cannot wrap before clamping
    always_comb begin
        nom_ext  = $signed({2'b00, nominal_inc});
        trim_ext = $signed({{(SUM_W - TRIM_W){trim[TRIM_W-1]}}, trim}) <<< STEP_SHIFT;
        sum      = nom_ext + trim_ext;
    end

    // Select nominal in preset, else clamp the trimmed sum to [0, 2^ACC_W-1]
    always_comb begin
        if (preset)
            inc = nominal_inc;
        else if (sum[SUM_W-1])
            inc = '0;
        else if (sum[ACC_W])
            inc = '1;
        else
            inc = sum[ACC_W-1:0];
    end

endmodule

// File: rtl/dcs_phase_acc.sv
// Phase accumulator that emits one enable pulse per carry-out.
// Does: acc += inc modulo 2^ACC_W each cycle; carry registered as enable.
// Assumes: inc is stable within a cycle (driven from registers/config).
module dcs_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc,
    output logic             smp_en
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic             carry;

    // Add with an extra bit to capture the carry
    always_comb {carry, acc_d} = {1'b0, acc_q} + {1'b0, inc};

    // Accumulator and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            smp_en <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            smp_en <= carry;
        end
    end

    // R2: an enable pulse appears exactly when the accumulator wrapped
    p_pulse_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (smp_en == (acc_q < $past(acc_q))));

endmodule

// File: rtl/dcs_sample_clock.sv
// Top of the digitally controlled sampling clock divider.
// Does: trims a nominal phase increment with up/down strobes and
//       swallows master cycles so the enable rate is inc/2^ACC_W of clk.
// Assumes: nominal_inc is quasi-static; strobes are synchronous pulses.
module dcs_sample_clock #(
    parameter int ACC_W      = 32,
    parameter int TRIM_LIMIT = 1024,
    parameter int STEP_SHIFT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] nominal_inc,
    input  logic             preset,
    input  logic             up_pulse,
    input  logic             dn_pulse,
    output logic             smp_en,
    output logic [ACC_W-1:0] cur_inc
);

    localparam int TRIM_W = $clog2(TRIM_LIMIT + 1) + 1;

    logic signed [TRIM_W-1:0] trim;

    dcs_trim_ctrl #(
        .TRIM_LIMIT (TRIM_LIMIT),
        .TRIM_W     (TRIM_W)
    ) u_trim (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset   (preset),
        .up_pulse (up_pulse),
        .dn_pulse (dn_pulse),
        .trim_q   (trim)
    );

    dcs_inc_sum #(
        .ACC_W      (ACC_W),
        .TRIM_W     (TRIM_W),
        .STEP_SHIFT (STEP_SHIFT)
    ) u_sum (
        .preset      (preset),
        .nominal_inc (nominal_inc),
        .trim        (trim),
        .inc         (cur_inc)
    );

    dcs_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (cur_inc),
        .smp_en (smp_en)
    );

    // R1: the cycle after reset the output is idle
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !smp_en);

endmodule

// File: tb/dcs_sample_clock_tb.sv
module dcs_sample_clock_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] nominal_inc = '0;
    logic        preset = 1'b1;
    logic        up_pulse = 1'b0;
    logic        dn_pulse = 1'b0;
    logic        smp_en;
    logic [31:0] cur_inc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dcs_sample_clock u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .nominal_inc (nominal_inc),
        .preset      (preset),
        .up_pulse    (up_pulse),
        .dn_pulse    (dn_pulse),
        .smp_en      (smp_en),
        .cur_inc     (cur_inc)
    );

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] nom, input logic pre);
        @(negedge clk);
        rst_n = 1'b0; nominal_inc = nom; preset = pre;
        up_pulse = 1'b0; dn_pulse = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic strobe(input logic u, input logic d, input int n);
        up_pulse = u; dn_pulse = d;
        repeat (n) @(negedge clk);
        up_pulse = 1'b0; dn_pulse = 1'b0;
        @(negedge clk);
    endtask

    // R1: state right after reset
    task automatic t_reset();
        do_reset(32'h1234_5678, 1'b0);
        check(smp_en == 1'b0, "R1 smp_en", smp_en, 0);
        check(cur_inc == 32'h1234_5678, "R1 cur_inc", cur_inc, 32'h1234_5678);
    endtask

    // R2/R3: pulse count and gap spacing over L cycles with a steady increment
    task automatic t_count(input logic [31:0] inc, input int len);
        longint exp_cnt, lo, hi, gmin, gmax, last, cnt;
        do_reset(inc, 1'b1);
        cnt = 0; last = -1; gmin = 64'h7fff_ffff; gmax = 0;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (smp_en) begin
                cnt++;
                if (last >= 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
            end
        end
        exp_cnt = (longint'(len) * longint'(inc)) >> 32;
        check(cnt == exp_cnt, "R2 pulse count", cnt, exp_cnt);
        if (inc != 0 && exp_cnt > 2) begin
            lo = (64'd1 << 32) / longint'(inc);
            hi = lo + (((64'd1 << 32) % longint'(inc)) != 0 ? 1 : 0);
            check(gmin >= lo, "R3 min gap", gmin, lo);
            check(gmax <= hi, "R3 max gap", gmax, hi);
        end
    endtask

    // R4/R5: stepping and holding of the trim
    task automatic t_steps();
        do_reset(32'd1_000_000, 1'b0);
        strobe(1'b1, 1'b0, 3);
        check(cur_inc == 32'd1_000_003, "R5 up steps", cur_inc, 1_000_003);
        strobe(1'b0, 1'b1, 5);
        check(cur_inc == 32'd999_998, "R5 down steps", cur_inc, 999_998);
        repeat (10) @(negedge clk);
        check(cur_inc == 32'd999_998, "R4 trim holds", cur_inc, 999_998);
    endtask

    // R7: both strobes together cancel
    task automatic t_cancel();
        strobe(1'b1, 1'b1, 4);
        check(cur_inc == 32'd999_998, "R7 cancel", cur_inc, 999_998);
    endtask

    // R6: saturation in both directions
    task automatic t_sat();
        do_reset(32'd1_000_000, 1'b0);
        strobe(1'b1, 1'b0, 1030);
        check(cur_inc == 32'd1_001_024, "R6 upper limit", cur_inc, 1_001_024);
        strobe(1'b0, 1'b1, 2060);
        check(cur_inc == 32'd998_976, "R6 lower limit", cur_inc, 998_976);
    endtask

    // R8: preset forces nominal, ignores strobes, clears trim
    task automatic t_preset();
        preset = 1'b1;
        strobe(1'b1, 1'b0, 6);
        check(cur_inc == 32'd1_000_000, "R8 nominal in preset", cur_inc, 1_000_000);
        preset = 1'b0;
        @(negedge clk);
        check(cur_inc == 32'd1_000_000, "R8 trim cleared", cur_inc, 1_000_000);
    endtask

    // R9: clamping at both ends of the range
    task automatic t_clamp();
        do_reset(32'd5, 1'b0);
        strobe(1'b0, 1'b1, 10);
        check(cur_inc == 32'd0, "R9 clamp low", cur_inc, 0);
        do_reset(32'hFFFF_FFF0, 1'b0);
        strobe(1'b1, 1'b0, 20);
        check(cur_inc == 32'hFFFF_FFFF, "R9 clamp high", cur_inc, 32'hFFFF_FFFF);
    endtask

    initial begin
        t_reset();
        t_count(32'h4000_0000, 100);
        t_count(32'd1_020_054_733, 1000);
        t_count(32'd0, 50);
        t_steps();
        t_cancel();
        t_sat();
        t_preset();
        t_clamp();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule